// File: doc/BRIEF.md
# Masked Vector Bitwise Logic Unit

This block applies one of four bitwise functions lane by lane to two 256-bit operands: AND, OR, XOR and a one-sided AND-NOT that complements only the first operand. The vector is cut either into eight 32-bit lanes or into four 64-bit lanes. An 8-bit predicate gives one bit per lane. A two-bit mode chooses how that predicate is used. In the plain form every lane is written. In the merge form a lane whose predicate bit is clear keeps the matching lane of a separate source vector. In the zeroing form such a lane is cleared to all zeros.

Data is handled as raw bits. Lanes that carry single- or double-precision values are treated exactly like 32- or 64-bit integers. The result and its valid flag are registered, so a result appears one clock after the input is accepted. A datapath feeds operands, the source vector, the predicate and the control fields together, with the valid input raised for one cycle per operation.

Top module: `vec_logic_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state has `out_valid` = 0 and `out_result` = all zeros.
- R2: `out_valid` after each rising edge equals `in_valid` sampled at that edge. The result of an accepted input is on `out_result` in the same cycle that `out_valid` rises.
- R3: With `opcode` 2'b00 each result bit is a AND b. With 2'b10 it is a OR b. With 2'b11 it is a XOR b.
- R4: With `opcode` 2'b01 each result bit is (NOT a) AND b. The complement is never applied to b.
- R5: With `elem64` = 0 the vector holds eight 32-bit lanes, where lane j is bits 32j+31:32j and `mask[j]` governs it. With `elem64` = 1 it holds four 64-bit lanes, where lane j is bits 64j+63:64j and `mask[j]` governs it.
- R6: With `elem64` = 1, mask bits 7:4 have no effect on the result.
- R7: With `mask_mode` 2'b00, or the reserved value 2'b11, every lane takes the computed value whatever the mask holds.
- R8: With `mask_mode` 2'b01 (merge), a lane whose mask bit is 0 takes the same lane of `src` unchanged.
- R9: With `mask_mode` 2'b10 (zeroing), a lane whose mask bit is 0 is all zeros.
- R10: A rising edge with `in_valid` = 0 leaves `out_result` unchanged and drives `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs hold an operation to perform |
| op_a | input | 256 | First operand; the one complemented by AND-NOT |
| op_b | input | 256 | Second operand |
| src | input | 256 | Pass-through vector for inactive lanes in merge mode |
| mask | input | 8 | Per-lane predicate; bit j governs lane j |
| opcode | input | 2 | 00 AND, 01 AND-NOT, 10 OR, 11 XOR |
| elem64 | input | 1 | 0: 32-bit lanes, 1: 64-bit lanes |
| mask_mode | input | 2 | 00 plain, 01 merge, 10 zeroing, 11 plain |
| out_valid | output | 1 | Registered result is fresh |
| out_result | output | 256 | Registered lane-wise result |

## Verification
The block holds little state: the result register and the valid flag. A fault in the lane-select decode, such as the wrong mask bit feeding a 64-bit lane half or a mode mapped to the wrong fill, shows as a single 32-bit stripe of `out_result` holding the source, zero or computed value in place of the correct one. It shows in the cycle right after the accepted input. A lost or extra valid, or a result register that loads while the input is idle, shows one cycle after the offending edge. The bench compares both outputs against a lane-loop model on every clock, so each of these faults is caught at its first occurrence.

// File: rtl/vlu_pkg.sv
`timescale 1ns/1ps
package vlu_pkg;

    localparam int VEC_W_DEF  = 256;
    localparam int LANE_W_DEF = 32;

    typedef enum logic [1:0] {
        OP_AND  = 2'b00,
        OP_ANDN = 2'b01,
        OP_OR   = 2'b10,
        OP_XOR  = 2'b11
    } vlu_op_e;

    typedef enum logic [1:0] {
        MM_PLAIN = 2'b00,
        MM_MERGE = 2'b01,
        MM_ZERO  = 2'b10,
        MM_RSVD  = 2'b11
    } vlu_mode_e;

    typedef enum logic [1:0] {
        SEL_CALC = 2'b00,
        SEL_SRC  = 2'b01,
        SEL_ZERO = 2'b10
    } lane_sel_e;

    // Fill choice for one stripe given the mode and whether its lane is active.
    function automatic lane_sel_e pick_sel(input vlu_mode_e mode, input logic active);
        lane_sel_e s;
        case (mode)
            MM_MERGE: s = active ? SEL_CALC : SEL_SRC;
            MM_ZERO:  s = active ? SEL_CALC : SEL_ZERO;
            default:  s = SEL_CALC;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/vlu_chunk_alu.sv
`timescale 1ns/1ps
module vlu_chunk_alu
    import vlu_pkg::*;
#(
    parameter int W = 32
) (
    input  vlu_op_e        op,
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [W-1:0]   z
);
    always_comb begin
        case (op)
            OP_AND:  z = x & y;
            OP_ANDN: z = (~x) & y;
            OP_OR:   z = x | y;
            default: z = x ^ y;
        endcase
    end
endmodule

// File: rtl/vlu_lane_ctrl.sv
`timescale 1ns/1ps
module vlu_lane_ctrl
    import vlu_pkg::*;
#(
    parameter int N_STRIPE = 8
) (
    input  logic [N_STRIPE-1:0]   mask,
    input  logic                  elem64,
    input  vlu_mode_e             mode,
    output lane_sel_e [N_STRIPE-1:0] sel
);
    // A stripe is one narrow lane; a wide lane covers stripes 2j and 2j+1.
    for (genvar c = 0; c < N_STRIPE; c++) begin : g_stripe
        localparam int WIDE_IDX = c / 2;
        logic active;
        assign active = elem64 ? mask[WIDE_IDX] : mask[c];
        assign sel[c] = pick_sel(mode, active);
    end
endmodule

// File: rtl/vlu_chunk_wb.sv
`timescale 1ns/1ps
module vlu_chunk_wb
    import vlu_pkg::*;
#(
    parameter int W = 32
) (
    input  lane_sel_e      sel,
    input  logic [W-1:0]   calc,
    input  logic [W-1:0]   keep,
    output logic [W-1:0]   z
);
    always_comb begin
        case (sel)
            SEL_CALC: z = calc;
            SEL_SRC:  z = keep;
            default:  z = '0;
        endcase
    end
endmodule

// File: rtl/vec_logic_unit.sv
`timescale 1ns/1ps
module vec_logic_unit
    import vlu_pkg::*;
#(
    parameter int VEC_W  = VEC_W_DEF,
    parameter int LANE_W = LANE_W_DEF,
    localparam int N_STRIPE = VEC_W / LANE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [VEC_W-1:0]     op_a,
    input  logic [VEC_W-1:0]     op_b,
    input  logic [VEC_W-1:0]     src,
    input  logic [N_STRIPE-1:0]  mask,
    input  logic [1:0]           opcode,
    input  logic                 elem64,
    input  logic [1:0]           mask_mode,
    output logic                 out_valid,
    output logic [VEC_W-1:0]     out_result
);
    vlu_op_e   op_sel;
    vlu_mode_e mode_sel;
    assign op_sel   = vlu_op_e'(opcode);
    assign mode_sel = vlu_mode_e'(mask_mode);

    lane_sel_e [N_STRIPE-1:0] sel;
    logic [VEC_W-1:0] calc_v;
    logic [VEC_W-1:0] res_d;

    vlu_lane_ctrl #(.N_STRIPE(N_STRIPE)) u_ctrl (
        .mask   (mask),
        .elem64 (elem64),
        .mode   (mode_sel),
        .sel    (sel)
    );

    for (genvar c = 0; c < N_STRIPE; c++) begin : g_stripe
        localparam int LO = c * LANE_W;
        vlu_chunk_alu #(.W(LANE_W)) u_alu (
            .op (op_sel),
            .x  (op_a[LO +: LANE_W]),
            .y  (op_b[LO +: LANE_W]),
            .z  (calc_v[LO +: LANE_W])
        );
        vlu_chunk_wb #(.W(LANE_W)) u_wb (
            .sel  (sel[c]),
            .calc (calc_v[LO +: LANE_W]),
            .keep (src[LO +: LANE_W]),
            .z    (res_d[LO +: LANE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= res_d;
            end
        end
    end
endmodule

// File: rtl/vec_logic_unit_chk.sv
`timescale 1ns/1ps
module vec_logic_unit_chk #(
    parameter int VEC_W  = 256,
    parameter int LANE_W = 32,
    localparam int N_STRIPE = VEC_W / LANE_W,
    localparam int N_WIDE   = N_STRIPE / 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [VEC_W-1:0]     op_a,
    input logic [VEC_W-1:0]     op_b,
    input logic [VEC_W-1:0]     src,
    input logic [N_STRIPE-1:0]  mask,
    input logic [1:0]           opcode,
    input logic                 elem64,
    input logic [1:0]           mask_mode,
    input logic                 out_valid,
    input logic [VEC_W-1:0]     out_result
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0));

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_valid_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));

    p_andnot_side_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask_mode == 2'b00 && opcode == 2'b01)
        |=> out_result == ($past(~op_a) & $past(op_b)));

    p_reserved_plain_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask_mode == 2'b11 && opcode == 2'b11)
        |=> out_result == ($past(op_a) ^ $past(op_b)));

    p_merge_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask_mode == 2'b01 && !elem64 && !mask[0])
        |=> out_result[LANE_W-1:0] == $past(src[LANE_W-1:0]));

    p_zero_fill_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask_mode == 2'b10 && !elem64 && !mask[0])
        |=> out_result[LANE_W-1:0] == '0);

    p_upper_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask_mode == 2'b01 && elem64 && mask[N_WIDE-1:0] == '0)
        |=> out_result == $past(src));
endmodule

bind vec_logic_unit vec_logic_unit_chk #(.VEC_W(VEC_W), .LANE_W(LANE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .op_a       (op_a),
    .op_b       (op_b),
    .src        (src),
    .mask       (mask),
    .opcode     (opcode),
    .elem64     (elem64),
    .mask_mode  (mask_mode),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/vec_logic_unit_test.sv
`timescale 1ns/1ps
module vec_logic_unit_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [255:0] op_a = '0, op_b = '0, src = '0;
    logic [7:0]   mask = '0;
    logic [1:0]   opcode = '0;
    logic         elem64 = 1'b0;
    logic [1:0]   mask_mode = '0;
    logic         out_valid;
    logic [255:0] out_result;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    string cur_req = "R1";
    string exp_tag = "R1";
    logic         exp_v = 1'b0;
    logic [255:0] exp_r = '0;

    always #2.5 clk = ~clk;

    vec_logic_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .src(src), .mask(mask),
        .opcode(opcode), .elem64(elem64), .mask_mode(mask_mode),
        .out_valid(out_valid), .out_result(out_result)
    );

    // Behavioural reference: walk lanes and bits with integers.
    function automatic logic [255:0] model(
        input logic [255:0] a, input logic [255:0] b, input logic [255:0] s,
        input logic [7:0] m, input logic [1:0] op, input logic wide, input logic [1:0] md);
        logic [255:0] r;
        int lw;
        int nl;
        logic x;
        logic on;
        r  = '0;
        lw = wide ? 64 : 32;
        nl = 256 / lw;
        for (int j = 0; j < nl; j++) begin
            on = (md == 2'b01 || md == 2'b10) ? m[j] : 1'b1;
            for (int k = 0; k < lw; k++) begin
                int p;
                p = j * lw + k;
                if (op == 2'b00)      x = a[p] & b[p];
                else if (op == 2'b01) x = !a[p] & b[p];
                else if (op == 2'b10) x = a[p] | b[p];
                else                  x = a[p] ^ b[p];
                if (on)                r[p] = x;
                else if (md == 2'b01)  r[p] = s[p];
                else                   r[p] = 1'b0;
            end
        end
        return r;
    endfunction

    always @(posedge clk) begin
        exp_tag <= cur_req;
        if (rst) begin
            exp_v <= 1'b0;
            exp_r <= '0;
        end else begin
            exp_v <= in_valid;
            if (in_valid) exp_r <= model(op_a, op_b, src, mask, opcode, elem64, mask_mode);
        end
    end

    task automatic check_vec(input string req, input logic [255:0] act, input logic [255:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s result act=%h exp=%h", req, act, expv);
        end
    endtask

    // Advance to the next falling edge and compare both outputs with the model.
    task automatic cyc();
        @(negedge clk);
        n_cmp++;
        if (out_valid !== exp_v) begin
            n_bad++;
            $display("FAIL R2 valid act=%0d exp=%0d (%s)", out_valid, exp_v, exp_tag);
        end
        check_vec(exp_tag, out_result, exp_r);
    endtask

    task automatic drive(input string req, input logic v, input logic [1:0] op,
                         input logic wide, input logic [1:0] md, input logic [7:0] m);
        cur_req   = req;
        in_valid  = v;
        opcode    = op;
        elem64    = wide;
        mask_mode = md;
        mask      = m;
    endtask

    task automatic rand_data();
        for (int w = 0; w < 8; w++) begin
            op_a[w*32 +: 32] = $urandom;
            op_b[w*32 +: 32] = $urandom;
            src[w*32 +: 32]  = $urandom;
        end
    endtask

    initial begin
        // R1: reset state
        rand_data();
        drive("R1", 1'b1, 2'b11, 1'b0, 2'b00, 8'hFF);
        cyc();
        cyc();
        @(negedge clk);
        rst = 1'b0;
        cur_req = "R1";
        in_valid = 1'b0;
        cyc();
        check_vec("R1", out_result, '0);

        // R4: directed, complement applies to op_a only
        op_a = {8{32'hFFFF0000}};
        op_b = {8{32'hFF00FF00}};
        drive("R4", 1'b1, 2'b01, 1'b0, 2'b00, 8'h00);
        cyc();
        check_vec("R4", out_result, {8{32'h0000FF00}});

        // R3: each binary function once, directed
        drive("R3", 1'b1, 2'b00, 1'b0, 2'b00, 8'h00);
        cyc();
        check_vec("R3", out_result, {8{32'hFF000000}});
        drive("R3", 1'b1, 2'b10, 1'b1, 2'b00, 8'h00);
        cyc();
        check_vec("R3", out_result, {8{32'hFFFFFF00}});
        drive("R3", 1'b1, 2'b11, 1'b0, 2'b11, 8'h00);
        cyc();
        check_vec("R7", out_result, {8{32'h00FFFF00}});

        // R6: wide lanes ignore mask bits 7:4
        src = {4{64'h0123456789ABCDEF}};
        drive("R6", 1'b1, 2'b00, 1'b1, 2'b01, 8'hF0);
        cyc();
        check_vec("R6", out_result, {4{64'h0123456789ABCDEF}});
        drive("R6", 1'b1, 2'b00, 1'b1, 2'b10, 8'hF0);
        cyc();
        check_vec("R6", out_result, '0);
        drive("R6", 1'b1, 2'b00, 1'b1, 2'b01, 8'h0F);
        cyc();
        check_vec("R6", out_result, {8{32'hFF000000}});

        // R5: one active lane at a time in each width
        for (int j = 0; j < 8; j++) begin
            rand_data();
            drive("R5", 1'b1, 2'b11, 1'b0, 2'b10, 8'(1 << j));
            cyc();
        end
        for (int j = 0; j < 4; j++) begin
            rand_data();
            drive("R5", 1'b1, 2'b00, 1'b1, 2'b01, 8'(1 << j) | 8'hA0);
            cyc();
        end

        // R10: idle cycles after a result
        drive("R10", 1'b0, 2'b10, 1'b0, 2'b10, 8'h00);
        rand_data();
        cyc();
        cyc();
        cyc();

        // Random sweep across every opcode, mode and width
        for (int i = 0; i < 600; i++) begin
            logic [1:0] op_r;
            logic [1:0] md_r;
            logic       v_r;
            string      tag;
            rand_data();
            op_r = 2'($urandom);
            md_r = 2'($urandom);
            v_r  = ($urandom % 5) != 0;
            if (!v_r)               tag = "R10";
            else if (md_r == 2'b01) tag = "R8";
            else if (md_r == 2'b10) tag = "R9";
            else if (op_r == 2'b01) tag = "R4";
            else if (md_r == 2'b11) tag = "R7";
            else                    tag = "R3";
            drive(tag, v_r, op_r, 1'($urandom), md_r, 8'($urandom));
            cyc();
        end

        drive("R10", 1'b0, 2'b00, 1'b0, 2'b00, 8'h00);
        cyc();
        cyc();

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule